// File: doc/BRIEF.md
# Component Video Output Formatter

This block sits at the output of a video decoder and maps three 10-bit component paths (luma or green, first colour difference or blue, second colour difference or red) onto three output buses named G/Y, B/U and R/V. Three mode bits select the format: a decimate bit, a 4:2:2 bit and a multiplex bit. In the decimated formats the two colour-difference inputs are reduced to one interleaved stream on B/U by plain sample dropping, steered by a per-sample colour-select phase bit.

A horizontal blanking input marks the interval between the end-of-active and the start-of-active timing words. During that interval some formats substitute fixed blanking codes. In the multiplexed format R/V also carries an alternating 512/64 pattern that restarts on every line. Mode bits are captured only at the start of each line, so a format change never splits a line. Outputs are registered with one cycle of latency behind a sample-valid strobe.

Top module: `comp_fmt_mux`

## Requirements
- R1: With decimate=0 and multiplex=0, each valid sample's three inputs appear unchanged on G/Y, B/U and R/V, both inside and outside blanking.
- R2: With decimate=1, G/Y carries the luma input outside blanking, and B/U carries the first colour-difference input when the colour-select bit is 0 and the second when it is 1.
- R3: With decimate=1 and multiplex=0, R/V is 0 on every sample.
- R4: With decimate=1 and 4:2:2=1, every blanking sample outputs G/Y=64 and B/U=512.
- R5: With decimate=1 and multiplex=1, R/V outputs 512 on the first blanking sample of a line, then alternates 64, 512, 64 on the following valid blanking samples, and is 0 on active samples. The pattern restarts at 512 on every line.
- R6: With decimate=0 and multiplex=1 (YC format), G/Y carries luma, B/U carries the first colour-difference input, and R/V is 0, with no blanking substitution.
- R7: With decimate=1 and 4:2:2=0, G/Y and B/U are not replaced during blanking.
- R8: Outputs update one clock after a sample with the valid bit set, out_vld is in_vld delayed by one clock, and outputs hold their value while in_vld is low.
- R9: A line starts at a valid sample with hblank=1 whose preceding valid sample had hblank=0; the first valid sample after reset also counts when hblank=1. The mode bits are captured at that sample and apply from that sample onward. Mode changes at other times have no effect until the next line start.
- R10: While reset is asserted, all outputs and out_vld are 0 and the captured mode is all zero, which is the pass-through format.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld | input | 1 | Input sample valid |
| in_y | input | 10 | Luma or green component |
| in_u | input | 10 | First colour difference or blue component |
| in_v | input | 10 | Second colour difference or red component |
| in_csel | input | 1 | Colour-select phase: 0 picks the first colour difference, 1 picks the second |
| in_hblank | input | 1 | High between the end-of-active and start-of-active timing words |
| mode_dec | input | 1 | Decimate chroma onto B/U |
| mode_422 | input | 1 | 4:2:2 blanking codes on G/Y and B/U |
| mode_mux | input | 1 | Multiplexed format: alternating R/V blanking pattern, or the YC format when decimate is low |
| out_vld | output | 1 | Output sample valid |
| out_gy | output | 10 | G/Y bus |
| out_bu | output | 10 | B/U bus |
| out_rv | output | 10 | R/V bus |

## Verification
The assertions assume that hblank is steady for a whole interval of valid samples. A blanking run is therefore always entered through a line-start sample, and the mode that applies to a blanking sample was captured in the same blanking run. The alternation check relies on the previous valid sample being a blanking sample of the same line. The bench drives every line as one or more blanking samples followed by active samples, with idle cycles only inside a run. The bench changes the mode bits only between lines, except in the one test that changes them on purpose in the middle of a line.

// File: rtl/fmt_pkg.sv
package fmt_pkg;
  typedef struct packed {
    logic dec;
    logic f422;
    logic mux;
  } fmt_mode_t;
endpackage

// File: rtl/fmt_line_track.sv
module fmt_line_track
  import fmt_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      vld,
  input  logic      hblank,
  input  fmt_mode_t mode_in,
  output logic      line_start,
  output fmt_mode_t mode_eff
);
  logic      prev_blank_q, prev_blank_d;
  fmt_mode_t mode_q, mode_d;

  always_comb begin
    line_start   = vld && hblank && !prev_blank_q;
    mode_eff     = line_start ? mode_in : mode_q;
    prev_blank_d = vld ? hblank : prev_blank_q;
    mode_d       = line_start ? mode_in : mode_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_blank_q <= 1'b0;
      mode_q       <= '0;
    end else begin
      prev_blank_q <= prev_blank_d;
      mode_q       <= mode_d;
    end
  end

  // R9: the captured mode only moves at a line start
  a_r9_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !line_start |=> $stable(mode_q));
endmodule

// File: rtl/fmt_rv_alt.sv
module fmt_rv_alt #(
  parameter int DW     = 10,
  parameter int ALT_HI = 512,
  parameter int ALT_LO = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          vld,
  input  logic          hblank,
  input  logic          line_start,
  output logic [DW-1:0] code
);
  logic phase_q, phase_d, cur;

  always_comb begin
    cur     = line_start ? 1'b0 : phase_q;
    code    = cur ? DW'(ALT_LO) : DW'(ALT_HI);
    phase_d = (vld && hblank) ? ~cur : phase_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= 1'b0;
    else        phase_q <= phase_d;
  end

  // R5: every line's pattern opens with the high code
  a_r5_restart: assert property (@(posedge clk) disable iff (!rst_n)
    line_start |-> (code == DW'(ALT_HI)));
endmodule

// File: rtl/fmt_select.sv
module fmt_select
  import fmt_pkg::*;
#(
  parameter int DW    = 10,
  parameter int Y_BLK = 64,
  parameter int C_BLK = 512
) (
  input  fmt_mode_t     mode,
  input  logic          hblank,
  input  logic          csel,
  input  logic [DW-1:0] y,
  input  logic [DW-1:0] u,
  input  logic [DW-1:0] v,
  input  logic [DW-1:0] alt_code,
  output logic [DW-1:0] gy,
  output logic [DW-1:0] bu,
  output logic [DW-1:0] rv
);
  logic [DW-1:0] chroma;

  always_comb begin
    chroma = csel ? v : u;
    if (!mode.dec) begin
      gy = y;
      bu = u;
      rv = mode.mux ? '0 : v;
    end else begin
      gy = (mode.f422 && hblank) ? DW'(Y_BLK) : y;
      bu = (mode.f422 && hblank) ? DW'(C_BLK) : chroma;
      rv = (mode.mux && hblank) ? alt_code : '0;
    end
  end
endmodule

// File: rtl/comp_fmt_mux.sv
module comp_fmt_mux
  import fmt_pkg::*;
#(
  parameter int DW     = 10,
  parameter int Y_BLK  = 64,
  parameter int C_BLK  = 512,
  parameter int ALT_HI = 512,
  parameter int ALT_LO = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_vld,
  input  logic [DW-1:0] in_y,
  input  logic [DW-1:0] in_u,
  input  logic [DW-1:0] in_v,
  input  logic          in_csel,
  input  logic          in_hblank,
  input  logic          mode_dec,
  input  logic          mode_422,
  input  logic          mode_mux,
  output logic          out_vld,
  output logic [DW-1:0] out_gy,
  output logic [DW-1:0] out_bu,
  output logic [DW-1:0] out_rv
);
  fmt_mode_t     mode_in, mode_eff;
  logic          line_start;
  logic [DW-1:0] alt_code;
  logic [DW-1:0] gy_d, bu_d, rv_d;

  assign mode_in = '{dec: mode_dec, f422: mode_422, mux: mode_mux};

  fmt_line_track u_track (
    .clk(clk), .rst_n(rst_n), .vld(in_vld), .hblank(in_hblank),
    .mode_in(mode_in), .line_start(line_start), .mode_eff(mode_eff)
  );

  fmt_rv_alt #(.DW(DW), .ALT_HI(ALT_HI), .ALT_LO(ALT_LO)) u_alt (
    .clk(clk), .rst_n(rst_n), .vld(in_vld), .hblank(in_hblank),
    .line_start(line_start), .code(alt_code)
  );

  fmt_select #(.DW(DW), .Y_BLK(Y_BLK), .C_BLK(C_BLK)) u_sel (
    .mode(mode_eff), .hblank(in_hblank), .csel(in_csel),
    .y(in_y), .u(in_u), .v(in_v), .alt_code(alt_code),
    .gy(gy_d), .bu(bu_d), .rv(rv_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_vld <= 1'b0;
      out_gy  <= '0;
      out_bu  <= '0;
      out_rv  <= '0;
    end else begin
      out_vld <= in_vld;
      if (in_vld) begin
        out_gy <= gy_d;
        out_bu <= bu_d;
        out_rv <= rv_d;
      end
    end
  end

  // R8: valid strobe delayed by one clock
  a_r8_latency: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld |=> out_vld);
  // R8: outputs hold while no sample arrives
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |=> ($stable(out_gy) && $stable(out_bu) && $stable(out_rv)));
  // R3: decimated, non-multiplexed formats leave R/V at zero
  a_r3_rv_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && mode_eff.dec && !mode_eff.mux) |=> (out_rv == '0));
  // R4: 4:2:2 blanking codes
  a_r4_blank_codes: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && in_hblank && mode_eff.dec && mode_eff.f422)
      |=> (out_gy == DW'(Y_BLK) && out_bu == DW'(C_BLK)));
  // R5: the blanking pattern alternates within a line
  a_r5_alternate: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && in_hblank && !line_start && mode_eff.dec && mode_eff.mux)
      |=> (out_rv != $past(out_rv)));
endmodule

// File: tb/test_comp_fmt_mux.sv
module test_comp_fmt_mux;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_vld = 1'b0;
  logic [9:0] in_y = '0, in_u = '0, in_v = '0;
  logic       in_csel = 1'b0, in_hblank = 1'b0;
  logic       mode_dec = 1'b0, mode_422 = 1'b0, mode_mux = 1'b0;
  logic       out_vld;
  logic [9:0] out_gy, out_bu, out_rv;
  int         n_checks = 0;
  int         n_errors = 0;

  always #2 clk = ~clk;

  comp_fmt_mux i_comp_fmt_mux (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_y(in_y), .in_u(in_u),
    .in_v(in_v), .in_csel(in_csel), .in_hblank(in_hblank),
    .mode_dec(mode_dec), .mode_422(mode_422), .mode_mux(mode_mux),
    .out_vld(out_vld), .out_gy(out_gy), .out_bu(out_bu), .out_rv(out_rv)
  );

  task automatic chk(input string req, input logic [9:0] act, input logic [9:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_mode(input logic d, input logic f, input logic m);
    mode_dec = d; mode_422 = f; mode_mux = m;
  endtask

  // one valid sample, checked one clock later
  task automatic px(input string req, input logic [9:0] y, input logic [9:0] u,
                    input logic [9:0] v, input logic cs, input logic hb,
                    input logic [9:0] ey, input logic [9:0] eu, input logic [9:0] ev);
    in_vld = 1'b1; in_y = y; in_u = u; in_v = v; in_csel = cs; in_hblank = hb;
    @(posedge clk); @(negedge clk);
    in_vld = 1'b0;
    chk({req, " vld"}, 10'(out_vld), 10'd1);
    chk({req, " gy"}, out_gy, ey);
    chk({req, " bu"}, out_bu, eu);
    chk({req, " rv"}, out_rv, ev);
  endtask

  task automatic t_reset;
    chk("R10 vld", 10'(out_vld), 10'd0);
    chk("R10 gy", out_gy, 10'd0);
    chk("R10 bu", out_bu, 10'd0);
    chk("R10 rv", out_rv, 10'd0);
    rst_n = 1'b1;
    @(negedge clk);
    // mode inputs not yet captured: pass-through applies
    set_mode(1, 1, 1);
    px("R10 R9 default mode", 10'd11, 10'd12, 10'd13, 1, 0, 10'd11, 10'd12, 10'd13);
  endtask

  task automatic t_passthrough;
    set_mode(0, 0, 0);
    px("R1 blank", 10'd5, 10'd6, 10'd7, 0, 1, 10'd5, 10'd6, 10'd7);
    px("R1 active", 10'd900, 10'd300, 10'd1023, 1, 0, 10'd900, 10'd300, 10'd1023);
  endtask

  task automatic t_decimate;
    set_mode(1, 0, 0);
    px("R7 R3 blank", 10'd40, 10'd41, 10'd42, 0, 1, 10'd40, 10'd41, 10'd0);
    px("R2 cb", 10'd100, 10'd200, 10'd300, 0, 0, 10'd100, 10'd200, 10'd0);
    px("R2 cr", 10'd101, 10'd201, 10'd301, 1, 0, 10'd101, 10'd301, 10'd0);
  endtask

  task automatic t_422;
    set_mode(1, 1, 0);
    px("R4 blank first", 10'd1, 10'd2, 10'd3, 0, 1, 10'd64, 10'd512, 10'd0);
    px("R4 blank next", 10'd4, 10'd5, 10'd6, 1, 1, 10'd64, 10'd512, 10'd0);
    px("R2 R3 active", 10'd700, 10'd710, 10'd720, 1, 0, 10'd700, 10'd720, 10'd0);
  endtask

  task automatic t_mux;
    set_mode(1, 0, 1);
    px("R5 first", 10'd20, 10'd21, 10'd22, 0, 1, 10'd20, 10'd21, 10'd512);
    px("R5 second", 10'd23, 10'd24, 10'd25, 1, 1, 10'd23, 10'd25, 10'd64);
    // idle cycle with different data: outputs hold, valid drops
    in_y = 10'd999; in_u = 10'd998; in_v = 10'd997; in_hblank = 1'b1;
    @(posedge clk); @(negedge clk);
    chk("R8 idle vld", 10'(out_vld), 10'd0);
    chk("R8 idle rv", out_rv, 10'd64);
    chk("R8 idle gy", out_gy, 10'd23);
    px("R5 third", 10'd26, 10'd27, 10'd28, 0, 1, 10'd26, 10'd27, 10'd512);
    px("R5 active", 10'd30, 10'd31, 10'd32, 0, 0, 10'd30, 10'd31, 10'd0);
    set_mode(1, 1, 1);
    px("R5 R4 restart", 10'd33, 10'd34, 10'd35, 0, 1, 10'd64, 10'd512, 10'd512);
    px("R5 R4 second", 10'd36, 10'd37, 10'd38, 0, 1, 10'd64, 10'd512, 10'd64);
    px("R5 active 2", 10'd39, 10'd40, 10'd41, 1, 0, 10'd39, 10'd41, 10'd0);
  endtask

  task automatic t_yc;
    set_mode(0, 1, 1);
    px("R6 blank", 10'd50, 10'd51, 10'd52, 1, 1, 10'd50, 10'd51, 10'd0);
    px("R6 active", 10'd53, 10'd54, 10'd55, 1, 0, 10'd53, 10'd54, 10'd0);
  endtask

  task automatic t_midline;
    set_mode(0, 0, 0);
    px("R9 start", 10'd60, 10'd61, 10'd62, 0, 1, 10'd60, 10'd61, 10'd62);
    set_mode(1, 1, 0);
    px("R9 ignored blank", 10'd63, 10'd64, 10'd65, 1, 1, 10'd63, 10'd64, 10'd65);
    px("R9 ignored active", 10'd66, 10'd67, 10'd68, 1, 0, 10'd66, 10'd67, 10'd68);
    px("R9 next line", 10'd69, 10'd70, 10'd71, 1, 1, 10'd64, 10'd512, 10'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_passthrough();
    t_decimate();
    t_422();
    t_mux();
    t_yc();
    t_midline();
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_errors++;
    n_checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule